// File: doc/BRIEF.md
# Timer Event Output Pin Generator

This block sits beside a timer counter and produces the level of the timer's external pin. The counter reports two single-cycle event strobes: counter overflow and compare match. Several fields of the timer control word select how those events act on the pin. A trigger mode chooses which events count. A mode bit chooses between inverting the pin and emitting a one-clock pulse. A default-level bit sets the resting level, and a direction bit decides whether the pin is driven at all.

When no trigger is selected, or when the timer is not running, the pin rests at the default level. Otherwise each qualifying event either flips the pin or pulses it to the opposite of the default level for one cycle. When the pin is configured as an input, the output enable drops and the output register keeps its last level. The control word is decoded directly, so the field bit positions are fixed by the neighbouring register.

Top module: `tmo_pin_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pin_out` is 0.
- R2: The control word fields are: default level at bit 7, trigger mode at bits 11:10, toggle select at bit 12 (1 = toggle, 0 = pulse), and direction at bit 14 (0 = output, 1 = input). All other bits of the control word have no effect on `pin_out` or `pin_oe`.
- R3: With direction output, if trigger mode is 0 (none) or 3 (same as none), `pin_out` equals the default-level bit after the next clock edge, whatever the events are.
- R4: With direction output and `timer_run` low, `pin_out` equals the default-level bit after the next clock edge, whatever the trigger mode and events are.
- R5: In trigger mode 1 (overflow only), only `ovf_evt` qualifies. A `match_evt` without `ovf_evt` has no effect on `pin_out`.
- R6: In trigger mode 2 (overflow and match), either strobe qualifies. If both strobes arrive in the same cycle, they count as one qualifying event: one inversion in toggle mode, and one pulse cycle in pulse mode.
- R7: In toggle mode, with direction output, `timer_run` high and trigger mode 1 or 2, a qualifying event inverts `pin_out` at the next edge. A cycle with no qualifying event leaves `pin_out` unchanged.
- R8: In pulse mode, under the same conditions, a qualifying event makes `pin_out` the inverse of the default level for the next cycle. A cycle with no qualifying event returns it to the default level. Back-to-back events keep the pulse level.
- R9: `pin_oe` is the inverse of the direction bit, combinationally. While the direction bit is 1, `pin_out` holds its value across the clock edge, whatever the mode, events and `timer_run` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | CTRL_W (16) | Timer control word; fields decoded as in R2 |
| timer_run | input | 1 | High while the counter is running |
| ovf_evt | input | 1 | One-cycle counter overflow strobe |
| match_evt | input | 1 | One-cycle compare match strobe |
| pin_out | output | 1 | Registered pin level |
| pin_oe | output | 1 | Pin output enable |

## Verification
An overflow and a match can land in the same cycle. This matters in trigger mode 2, where a careless merge would flip the pin twice (leaving it unchanged) or stretch a pulse. The sweep drives all four strobe combinations under every control setting, including the cycle where both are high. A reference model in the bench treats that cycle as one event and judges the pin one edge later. Mode 1 with only a match strobe is judged the same way, to show the match is ignored.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

  localparam int unsigned DFLT_BIT = 7;
  localparam int unsigned MODE_LO  = 10;
  localparam int unsigned TGL_BIT  = 12;
  localparam int unsigned DIR_BIT  = 14;
  localparam int unsigned MIN_CTRL_W = DIR_BIT + 1;

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'd0,
    TRIG_OVF   = 2'd1,
    TRIG_BOTH  = 2'd2,
    TRIG_RSVD  = 2'd3
  } trig_mode_e;

  typedef struct packed {
    logic       dir_in;
    logic       toggle;
    trig_mode_e mode;
    logic       dflt;
  } pin_cfg_t;

  // Qualifying event for a mode: the arithmetic of which strobes count.
  function automatic logic event_hits(trig_mode_e m, logic ovf, logic mat);
    case (m)
      TRIG_OVF:  return ovf;
      TRIG_BOTH: return ovf | mat;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic mode_active(trig_mode_e m);
    return (m == TRIG_OVF) || (m == TRIG_BOTH);
  endfunction

endpackage

// File: rtl/tmo_cfg_decode.sv
module tmo_cfg_decode
  import tmo_pkg::*;
#(
  parameter int unsigned CTRL_W = 16
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  output pin_cfg_t          cfg
);

  localparam int unsigned MODE_HI = MODE_LO + 1;

  if (CTRL_W < MIN_CTRL_W) begin : g_bad_width
    initial $error("tmo_cfg_decode: CTRL_W too small");
  end

  logic [CTRL_W-1:0] unused_bits;

  always_comb begin
    cfg.dflt   = ctrl_word[DFLT_BIT];
    cfg.mode   = trig_mode_e'(ctrl_word[MODE_HI:MODE_LO]);
    cfg.toggle = ctrl_word[TGL_BIT];
    cfg.dir_in = ctrl_word[DIR_BIT];
    unused_bits = ctrl_word;
  end

endmodule

// File: rtl/tmo_event_qual.sv
module tmo_event_qual
  import tmo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       ovf_evt,
  input  logic       match_evt,
  output logic       trig_active,
  output logic       ev_hit
);

  always_comb begin
    trig_active = mode_active(mode);
    ev_hit      = event_hits(mode, ovf_evt, match_evt);
  end

  // R5: a lone match does nothing in overflow-only mode
  p_match_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_OVF && !ovf_evt) |-> !ev_hit);

  // R3: inactive modes never qualify
  p_none_no_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_active |-> !ev_hit);

endmodule

// File: rtl/tmo_level_reg.sv
module tmo_level_reg
  import tmo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  pin_cfg_t cfg,
  input  logic     run,
  input  logic     trig_active,
  input  logic     ev_hit,
  output logic     lvl_q
);

  logic hold_in, rest, flip, pulse_on;
  logic lvl_d;

  always_comb begin
    hold_in  = cfg.dir_in;
    rest     = !cfg.dir_in && (!run || !trig_active);
    flip     = !hold_in && !rest && cfg.toggle && ev_hit;
    pulse_on = !hold_in && !rest && !cfg.toggle && ev_hit;
    if (hold_in)             lvl_d = lvl_q;
    else if (rest)           lvl_d = cfg.dflt;
    else if (flip)           lvl_d = ~lvl_q;
    else if (pulse_on)       lvl_d = ~cfg.dflt;
    else if (!cfg.toggle)    lvl_d = cfg.dflt;
    else                     lvl_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_d;
  end

  // R9: input direction freezes the level
  p_hold_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.dir_in |=> $stable(lvl_q));

  // R4: stopped timer rests at default
  p_stop_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.dir_in && !run) |=> (lvl_q == $past(cfg.dflt)));

  // R3: no trigger rests at default
  p_idle_default_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.dir_in && !trig_active) |=> (lvl_q == $past(cfg.dflt)));

  // R7: toggle flips on a hit
  p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.dir_in && run && trig_active && cfg.toggle && ev_hit)
      |=> (lvl_q != $past(lvl_q)));

  // R8: pulse takes the inverse of default
  p_pulse_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.dir_in && run && trig_active && !cfg.toggle && ev_hit)
      |=> (lvl_q == !$past(cfg.dflt)));

endmodule

// File: rtl/tmo_pin_gen.sv
module tmo_pin_gen
  import tmo_pkg::*;
#(
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              timer_run,
  input  logic              ovf_evt,
  input  logic              match_evt,
  output logic              pin_out,
  output logic              pin_oe
);

  pin_cfg_t cfg;
  logic     trig_active;
  logic     ev_hit;
  logic     lvl_q;

  tmo_cfg_decode #(.CTRL_W(CTRL_W)) u_dec (
    .ctrl_word (ctrl_word),
    .cfg       (cfg)
  );

  tmo_event_qual u_qual (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (cfg.mode),
    .ovf_evt     (ovf_evt),
    .match_evt   (match_evt),
    .trig_active (trig_active),
    .ev_hit      (ev_hit)
  );

  tmo_level_reg u_lvl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .run         (timer_run),
    .trig_active (trig_active),
    .ev_hit      (ev_hit),
    .lvl_q       (lvl_q)
  );

  assign pin_out = lvl_q;
  assign pin_oe  = ~cfg.dir_in;

  // R1: output low right out of reset
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_n |=> !pin_out);

endmodule

// File: tb/tb_tmo_pin_gen.sv
module tb_tmo_pin_gen;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] ctrl_word = '0;
  logic          timer_run = 1'b0;
  logic          ovf_evt = 1'b0;
  logic          match_evt = 1'b0;
  logic          pin_out, pin_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmo_pin_gen #(.CTRL_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .timer_run(timer_run),
    .ovf_evt(ovf_evt), .match_evt(match_evt), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // Independent reference of the next pin level.
  function automatic logic model(logic prev, logic dflt, int mode, logic tgl,
                                 logic dir, logic run, logic ovf, logic mat);
    logic hit;
    if (dir) return prev;
    if (!run || mode == 0 || mode == 3) return dflt;
    hit = (mode == 1) ? ovf : (ovf || mat);
    if (tgl) return hit ? !prev : prev;
    return hit ? !dflt : dflt;
  endfunction

  function automatic string tag_of(logic dir, logic run, int mode, logic tgl,
                                   logic ovf, logic mat);
    if (dir) return "R9";
    if (!run) return "R4";
    if (mode == 0 || mode == 3) return "R3";
    if (mode == 1 && mat && !ovf) return "R5";
    if (mode == 2 && mat && ovf) return "R6";
    return tgl ? "R7" : "R8";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic exp;
    string last_tag;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", pin_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", pin_out, 1'b0);
    exp = 1'b0;
    last_tag = "R1";

    for (int pass = 0; pass < 2; pass++) begin
      for (int cfg = 0; cfg < 64; cfg++) begin
        logic dflt, tgl, dir, run;
        int mode;
        logic [CW-1:0] junk;
        dflt = cfg[0];
        mode = (cfg >> 1) & 3;
        tgl  = cfg[3];
        dir  = cfg[4];
        run  = cfg[5];
        // R2: non-field bits are all ones on the second pass
        junk = (pass == 1) ? ~((CW'(1) << 7) | (CW'(3) << 10) |
                               (CW'(1) << 12) | (CW'(1) << 14)) : '0;
        for (int st = 0; st < 10; st++) begin
          logic ovf, mat;
          ovf = (st % 4) >= 2;
          mat = (st % 2) == 1;
          if (st == 8) begin ovf = 1'b1; mat = 1'b1; end
          if (st == 9) begin ovf = 1'b0; mat = 1'b0; end
          ctrl_word = junk;
          ctrl_word[7] = dflt;
          ctrl_word[11:10] = mode[1:0];
          ctrl_word[12] = tgl;
          ctrl_word[14] = dir;
          timer_run = run;
          ovf_evt = ovf;
          match_evt = mat;
          #1;
          check((pass == 1) ? "R2" : "R9", pin_oe, !dir);
          exp = model(exp, dflt, mode, tgl, dir, run, ovf, mat);
          last_tag = tag_of(dir, run, mode, tgl, ovf, mat);
          @(negedge clk);
          check((pass == 1) ? "R2" : last_tag, pin_out, exp);
        end
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule